// File: doc/BRIEF.md
# Twelve-bit pointer-addressed processor core

This is a small multi-cycle processor with a 12-bit word. It runs programs from one word-addressed memory of 4096 words through a synchronous port: an address and a write strobe are presented in one cycle, and read data returns in the next. The core holds eight 12-bit general registers and a program counter. A data pointer supplies the address for every data load and store, and a stack pointer serves push and pop. A zero flag records the outcome of arithmetic and logic. A small side map can be written from a register and read back into a register, with entries picked by the low bits of the pointer.

Every instruction passes through named states. ST_FETCH presents the program counter on the memory port and always moves to ST_LOAD_IR. ST_LOAD_IR captures the returned word and always moves to ST_EXEC. ST_EXEC carries out the instruction. From there the core goes to ST_MEM_RD when the instruction reads data memory (a load or a pop). It goes to ST_HALT on a halt or an undefined encoding. Every other instruction returns to ST_FETCH. ST_MEM_RD writes the returned word into the register file and returns to ST_FETCH. ST_HALT is left only by reset.

The pointer can be loaded only from a 7-bit immediate, so the low 128 words of memory are the only data area it reaches directly. The stack grows downward from the top of memory.

Top module: `tiny12_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the core presents address 0, `mem_we` is 0, and `halted` and `illegal` are 0. The stack pointer starts at 0xFFF, and the registers, the pointer and the zero flag start at 0.
- R2: Instructions are fetched from the program counter. Each instruction that is not a taken branch advances the counter by one. Word 0x000 (no operation) and word 0x002 (software trap, no further effect here) change only the counter.
- R3: A word whose bits 11:7 are 00001 loads the pointer with bits 6:0, zero-extended. Word 0x020+r loads register r from memory at the pointer. Word 0x028+r stores register r to memory at the pointer.
- R4: A word with bits 11:9 nonzero is a three-register operation. The destination is in bits 8:6, operand A in bits 5:3 and operand B in bits 2:0. The code in bits 11:9 selects: 1 AND, 2 OR, 3 NAND, 4 A plus the complement of B plus one, 5 XOR, 6 NOR, 7 ADD.
- R5: Words 0x100, 0x140, 0x180 and 0x1C0 (destination in bits 5:3, source in bits 2:0) give, in that order: logical shift left by one, logical shift right by one, increment, decrement.
- R6: Each operation in R4 and R5 sets the zero flag when its 12-bit result is zero and clears it otherwise. No other instruction changes the flag.
- R7: Word 0x003 loads the program counter from the pointer when the zero flag is clear, and advances the counter by one when the flag is set.
- R8: Word 0x030+r decrements the stack pointer and then writes register r at the new address. Word 0x038+r reads memory at the stack pointer into register r and then increments the stack pointer.
- R9: Word 0x018+r copies register r into the side-map entry selected by the low pointer bits. Word 0x010+r copies that entry into register r.
- R10: Word 0x001 stops the core. `halted` then stays high, no later fetch or write occurs, and the address stays constant.
- R11: Every undefined encoding (0x004-0x00F, 0x040-0x07F) raises `illegal` and halts the core without writing anything.
- R12: Every result wraps modulo 4096, and so do stack pointer and counter updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 12 | Read data, valid one cycle after the address |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | An undefined encoding was executed |

## Verification
Internal state can be seen only through memory traffic, so the test programs copy registers out with stores and then check memory. A wrong ALU result or a wrong register index shows up in the stored word within the next few instructions. A wrong zero flag sends the branch to the wrong store location, so one of two marker cells is written in place of the other. A stack pointer that is off by one places pushed words at the wrong addresses and reverses the order of popped words. A missing halt shows up as a write to a cell that should be left alone, one instruction after the halt.

// File: rtl/t12_pkg.sv
package t12_pkg;
    localparam int WORD_W = 12;
    localparam int REG_AW = 3;
    localparam int NREG   = 1 << REG_AW;
    localparam int IMM_W  = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        OP_NOP, OP_HLT, OP_INT, OP_BNZ, OP_GET, OP_SET, OP_LOD,
        OP_STR, OP_PSH, OP_POP, OP_LDI, OP_ALU, OP_ILL
    } op_e;

    typedef enum logic [3:0] {
        AF_LSH, AF_RSH, AF_INC, AF_DEC, AF_AND, AF_OR,
        AF_NAND, AF_SUB, AF_XOR, AF_NOR, AF_ADD
    } alu_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_LOAD_IR, ST_EXEC, ST_MEM_RD, ST_HALT
    } state_e;
endpackage

// File: rtl/t12_decode.sv
module t12_decode
    import t12_pkg::*;
(
    input  word_t             instr,
    output op_e               op,
    output alu_e              fn,
    output logic [REG_AW-1:0] rd,
    output logic [REG_AW-1:0] ra,
    output logic [REG_AW-1:0] rb
);
    always_comb begin
        op = OP_ILL;
        fn = AF_ADD;
        rd = instr[2:0];
        ra = instr[2:0];
        rb = instr[2:0];
        if (instr[11:9] != 3'd0) begin
            // three-register group
            op = OP_ALU;
            rd = instr[8:6];
            ra = instr[5:3];
            case (instr[11:9])
                3'd1:    fn = AF_AND;
                3'd2:    fn = AF_OR;
                3'd3:    fn = AF_NAND;
                3'd4:    fn = AF_SUB;
                3'd5:    fn = AF_XOR;
                3'd6:    fn = AF_NOR;
                default: fn = AF_ADD;
            endcase
        end else if (instr[8]) begin
            // two-register group
            op = OP_ALU;
            rd = instr[5:3];
            case (instr[7:6])
                2'd0:    fn = AF_LSH;
                2'd1:    fn = AF_RSH;
                2'd2:    fn = AF_INC;
                default: fn = AF_DEC;
            endcase
        end else if (instr[7]) begin
            op = OP_LDI;
        end else if (instr[6]) begin
            op = OP_ILL;
        end else begin
            case (instr[5:3])
                3'd0: begin
                    case (instr[2:0])
                        3'd0:    op = OP_NOP;
                        3'd1:    op = OP_HLT;
                        3'd2:    op = OP_INT;
                        3'd3:    op = OP_BNZ;
                        default: op = OP_ILL;
                    endcase
                end
                3'd2:    op = OP_GET;
                3'd3:    op = OP_SET;
                3'd4:    op = OP_LOD;
                3'd5:    op = OP_STR;
                3'd6:    op = OP_PSH;
                3'd7:    op = OP_POP;
                default: op = OP_ILL;
            endcase
        end
    end
endmodule

// File: rtl/t12_alu.sv
module t12_alu
    import t12_pkg::*;
(
    input  alu_e  fn,
    input  word_t a,
    input  word_t b,
    output word_t y,
    output logic  zero
);
    always_comb begin
        unique case (fn)
            AF_LSH:  y = a << 1;
            AF_RSH:  y = a >> 1;
            AF_INC:  y = a + word_t'(1);
            AF_DEC:  y = a - word_t'(1);
            AF_AND:  y = a & b;
            AF_OR:   y = a | b;
            AF_NAND: y = ~(a & b);
            AF_SUB:  y = a + ~b + word_t'(1);
            AF_XOR:  y = a ^ b;
            AF_NOR:  y = ~(a | b);
            AF_ADD:  y = a + b;
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/t12_regs.sv
module t12_regs
    import t12_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  word_t             wdata,
    input  logic [REG_AW-1:0] ra,
    input  logic [REG_AW-1:0] rb,
    output word_t             qa,
    output word_t             qb
);
    word_t regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
endmodule

// File: rtl/tiny12_core.sv
module tiny12_core
    import t12_pkg::*;
#(
    parameter int MAP_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] mem_rdata,
    output logic [11:0] mem_addr,
    output logic [11:0] mem_wdata,
    output logic        mem_we,
    output logic        halted,
    output logic        illegal
);
    localparam int MAP_AW = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;
    localparam word_t SP_INIT = '1;

    state_e state_q, state_d;
    word_t  pc_q, ptr_q, sp_q, ir_q;
    logic   zf_q, ill_q;
    word_t  map_q [MAP_DEPTH];

    op_e               op;
    alu_e              fn;
    logic [REG_AW-1:0] rd, ra, rb;
    word_t             qa, qb, alu_y;
    logic              alu_zero;
    logic              rf_we;
    word_t             rf_wdata;
    logic [MAP_AW-1:0] map_idx;

    assign map_idx = ptr_q[MAP_AW-1:0];

    t12_decode u_dec (.instr(ir_q), .op(op), .fn(fn), .rd(rd), .ra(ra), .rb(rb));
    t12_alu    u_alu (.fn(fn), .a(qa), .b(qb), .y(alu_y), .zero(alu_zero));
    t12_regs   u_rf  (.clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rd),
                      .wdata(rf_wdata), .ra(ra), .rb(rb), .qa(qa), .qb(qb));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   state_d = ST_LOAD_IR;
            ST_LOAD_IR: state_d = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_HLT || op == OP_ILL)      state_d = ST_HALT;
                else if (op == OP_LOD || op == OP_POP) state_d = ST_MEM_RD;
                else                                   state_d = ST_FETCH;
            end
            ST_MEM_RD:  state_d = ST_FETCH;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = qb;
        mem_we    = 1'b0;
        halted    = (state_q == ST_HALT);
        illegal   = ill_q;
        if (state_q == ST_EXEC) begin
            case (op)
                OP_LOD: mem_addr = ptr_q;
                OP_STR: begin mem_addr = ptr_q; mem_we = 1'b1; end
                OP_PSH: begin mem_addr = sp_q - word_t'(1); mem_we = 1'b1; end
                OP_POP: mem_addr = sp_q;
                default: ;
            endcase
        end
    end

    // register file write port
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_y;
        if (state_q == ST_MEM_RD) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
        end else if (state_q == ST_EXEC && op == OP_ALU) begin
            rf_we = 1'b1;
        end else if (state_q == ST_EXEC && op == OP_GET) begin
            rf_we    = 1'b1;
            rf_wdata = map_q[map_idx];
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ptr_q <= '0;
            sp_q  <= SP_INIT;
            ir_q  <= '0;
            zf_q  <= 1'b0;
            ill_q <= 1'b0;
            for (int i = 0; i < MAP_DEPTH; i++) map_q[i] <= '0;
        end else if (state_q == ST_LOAD_IR) begin
            ir_q <= mem_rdata;
        end else if (state_q == ST_EXEC) begin
            unique case (op)
                OP_HLT: ;
                OP_ILL: ill_q <= 1'b1;
                OP_BNZ: pc_q <= zf_q ? pc_q + word_t'(1) : ptr_q;
                OP_LDI: begin
                    ptr_q <= word_t'(ir_q[IMM_W-1:0]);
                    pc_q  <= pc_q + word_t'(1);
                end
                OP_ALU: begin
                    zf_q <= alu_zero;
                    pc_q <= pc_q + word_t'(1);
                end
                OP_SET: begin
                    map_q[map_idx] <= qb;
                    pc_q <= pc_q + word_t'(1);
                end
                OP_PSH: begin
                    sp_q <= sp_q - word_t'(1);
                    pc_q <= pc_q + word_t'(1);
                end
                OP_POP: begin
                    sp_q <= sp_q + word_t'(1);
                    pc_q <= pc_q + word_t'(1);
                end
                default: pc_q <= pc_q + word_t'(1);
            endcase
        end
    end
endmodule

// File: rtl/t12_checker.sv
module t12_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] mem_addr,
    input logic        mem_we,
    input logic        halted,
    input logic        illegal
);
    // R10: a halted core never writes
    p_no_write_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R10: halt is permanent and the address freezes
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr)));

    // R11: an illegal encoding always halts
    p_illegal_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R11: the illegal flag is sticky
    p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    // R2: a write cycle is always followed by a fetch, never by another write
    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind tiny12_core t12_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_we(mem_we), .halted(halted), .illegal(illegal)
);

// File: tb/sim_tiny12_core.sv
module sim_tiny12_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_rdata;
    logic [11:0] mem_addr, mem_wdata;
    logic        mem_we, halted, illegal;
    logic [11:0] mem [4096];
    int          n_chk = 0;
    int          n_err = 0;
    int          cycles = 0;

    tiny12_core u0 (.clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
                    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .illegal(illegal));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 12'h000;
        @(negedge clk);
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk("R10 halted", {11'd0, halted}, 12'd1);
    endtask

    // bench model of the arithmetic: kinds 0..10
    function automatic logic [11:0] ref_alu(input int k, input logic [11:0] a, input logic [11:0] b);
        case (k)
            0: return a << 1;
            1: return a >> 1;
            2: return a + 12'd1;
            3: return a - 12'd1;
            4: return a & b;
            5: return a | b;
            6: return ~(a & b);
            7: return a - b;
            8: return a ^ b;
            9: return ~(a | b);
            default: return a + b;
        endcase
    endfunction

    function automatic logic [11:0] enc_alu(input int k);
        if (k < 4) return 12'h100 | 12'(k << 6) | 12'h019;   // dst r3, src r1
        return 12'((k - 3) << 9) | 12'h0CA;                   // dst r3, A r1, B r2
    endfunction

    task automatic alu_test(input int k, input logic [11:0] a, input logic [11:0] b);
        logic [11:0] e;
        e = ref_alu(k, a, b);
        hold_reset();
        mem[0] = 12'h0F0; mem[1] = 12'h021; mem[2] = 12'h0F1; mem[3] = 12'h022;
        mem[4] = enc_alu(k);
        mem[5] = 12'h0F2; mem[6] = 12'h02B; mem[7] = 12'h0A0; mem[8] = 12'h003;
        mem[9] = 12'h0F4; mem[10] = 12'h02B; mem[11] = 12'h001;
        mem[12'h20] = 12'h0F5; mem[12'h21] = 12'h02B; mem[12'h22] = 12'h001;
        mem[12'h70] = a; mem[12'h71] = b;
        mem[12'h74] = e ^ 12'h001; mem[12'h75] = e ^ 12'h001;
        run_to_halt();
        chk((k < 4) ? "R5 R12 result" : "R4 R12 result", mem[12'h72], e);
        if (e == 12'h000) begin
            chk("R6 R7 zero set, fall through", mem[12'h74], e);
            chk("R6 R7 no branch store", mem[12'h75], e ^ 12'h001);
        end else begin
            chk("R6 R7 zero clear, branch", mem[12'h75], e);
            chk("R6 R7 no fall-through store", mem[12'h74], e ^ 12'h001);
        end
    endtask

    initial begin
        int seed;
        logic [11:0] a, b;
        seed = $urandom(32'd2024);

        // R1: reset state
        hold_reset();
        chk("R1 addr in reset", mem_addr, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first fetch address", mem_addr, 12'h000);
        chk("R1 no write", {11'd0, mem_we}, 12'd0);
        chk("R1 halted low", {11'd0, halted}, 12'd0);
        chk("R1 illegal low", {11'd0, illegal}, 12'd0);

        // directed arithmetic corners (R4 R5 R6 R12)
        alu_test(7, 12'h000, 12'h001);
        alu_test(7, 12'h5A5, 12'h5A5);
        alu_test(2, 12'hFFF, 12'h000);
        alu_test(3, 12'h000, 12'h000);
        alu_test(0, 12'h800, 12'h000);
        alu_test(1, 12'h001, 12'h000);
        alu_test(10, 12'hFFF, 12'h001);
        alu_test(6, 12'hFFF, 12'hFFF);
        alu_test(9, 12'hFFF, 12'h000);

        // constrained random
        for (int t = 0; t < 60; t++) begin
            int k;
            k = int'($urandom % 11);
            a = 12'($urandom);
            b = ($urandom % 4 == 0) ? a : 12'($urandom);
            alu_test(k, a, b);
        end

        // R2 R8: stack order, with no-op and trap prefix
        a = 12'h3C1; b = 12'hA0E;
        hold_reset();
        mem[0] = 12'h000; mem[1] = 12'h002; mem[2] = 12'h0F0; mem[3] = 12'h021;
        mem[4] = 12'h031; mem[5] = 12'h0F1; mem[6] = 12'h022; mem[7] = 12'h032;
        mem[8] = 12'h03C; mem[9] = 12'h03D; mem[10] = 12'h0F2; mem[11] = 12'h02C;
        mem[12] = 12'h0F3; mem[13] = 12'h02D; mem[14] = 12'h001;
        mem[12'h70] = a; mem[12'h71] = b;
        run_to_halt();
        chk("R8 first push at 0xFFE", mem[12'hFFE], a);
        chk("R8 second push at 0xFFD", mem[12'hFFD], b);
        chk("R8 first pop returns last push", mem[12'h72], b);
        chk("R8 second pop", mem[12'h73], a);
        chk("R2 stop address after halt", mem_addr, 12'h00E);

        // R9: side map write and read-back
        hold_reset();
        mem[0] = 12'h0F0; mem[1] = 12'h021; mem[2] = 12'h085; mem[3] = 12'h019;
        mem[4] = 12'h086; mem[5] = 12'h018; mem[6] = 12'h085; mem[7] = 12'h016;
        mem[8] = 12'h0F2; mem[9] = 12'h02E; mem[10] = 12'h001;
        mem[12'h70] = 12'h6B2;
        run_to_halt();
        chk("R9 map read-back", mem[12'h72], 12'h6B2);

        // R3: pointer immediate upper edge
        hold_reset();
        mem[0] = 12'h0FF; mem[1] = 12'h028; mem[2] = 12'h001;
        mem[12'h7F] = 12'h123;
        run_to_halt();
        chk("R3 store at pointer 0x7F", mem[12'h7F], 12'h000);

        // R10: halt blocks the following store
        hold_reset();
        mem[0] = 12'h001; mem[1] = 12'h0F0; mem[2] = 12'h028;
        mem[12'h70] = 12'h5A5;
        run_to_halt();
        repeat (8) @(negedge clk);
        chk("R10 cell untouched after halt", mem[12'h70], 12'h5A5);
        chk("R10 illegal stays low", {11'd0, illegal}, 12'd0);

        // R11: two undefined encodings
        for (int v = 0; v < 2; v++) begin
            hold_reset();
            mem[0] = 12'h0F0; mem[1] = (v == 0) ? 12'h04A : 12'h00C; mem[2] = 12'h028;
            mem[12'h70] = 12'h5A5;
            run_to_halt();
            repeat (6) @(negedge clk);
            chk("R11 illegal raised", {11'd0, illegal}, 12'd1);
            chk("R11 no write after illegal", mem[12'h70], 12'h5A5);
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule